// File: doc/BRIEF.md
# Wake Debounce and Interrupt Controller

This block turns a supply-above-threshold comparator into a clean wake signal for a host processor. The comparator must stay high across several measurement windows before the wake output rises. Any drop of the comparator restarts the count. The wake output is held low while the chip sleeps or is shut down. A host override bit can force the output high.

The block also collects five status bits and keeps one change-detect interrupt bit for each of them. An interrupt bit sets when its status bit changes in either direction. Reading the interrupt register clears every bit, and a per-source mask keeps a source off the interrupt pin. By default that pin is an active-low open-drain request. A configuration bit turns it into a push-pull drive for an external input clamp.

Top module: `wake_irq_ctrl`

## Requirements
- R1: `wake_o` rises only after `sys_above_i` has been high through DEB_WINDOWS (default 8) `win_end_i` strobes with no drop in between. The first strobe may close a partial window, so the delay is 7 to 8 full windows. Once reached, the count saturates and further strobes keep `wake_o` high.
- R2: A low `sys_above_i` on any clock edge restarts the count, so a fresh run of DEB_WINDOWS strobes is needed afterwards.
- R3: While `sleep_i` or `shutdown_i` is high, `wake_o` is low and the window count is cleared. This holds even when the override is set.
- R4: `force_wake_i` drives `wake_o` high regardless of the comparator, unless R3 applies.
- R5: `status_o[0]` reads 0 when the comparator path holds wake high and 1 when it holds wake low. It ignores `force_wake_i`.
- R6: The status bit positions are: 4 harvest-ready, 3 VOC-ready, 2 VOC-valid, 1 enable-status (these come from `src_stat_i[3:0]`), and 0 wake-status. A change of status bit n in either direction sets `irq_o[n]` on the next clock edge.
- R7: A one-cycle `irq_rd_i` clears all `irq_o` bits on the next edge. A status change in the same cycle as the read still sets its bit.
- R8: `mask_wr_i` loads `mask_wdata_i` into `mask_o` (reset value 0). In open-drain mode (`clamp_mode_i`=0), `irq_pad_oe_o`=1 with `irq_pad_out_o`=0 exactly when some `irq_o` bit is set and its mask bit is 0. Otherwise `irq_pad_oe_o`=0.
- R9: In clamp mode (`clamp_mode_i`=1), `irq_pad_oe_o`=1. `irq_pad_out_o` is 1 in shutdown, 0 during `voc_meas_i` or `sleep_i`, and otherwise equals `clamp_req_i`. Shutdown has the highest priority.
- R10: No interrupt bit is set by the status values present when reset is released. The first edge after reset only captures the reference values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_above_i | input | 1 | Supply-above-wake-threshold comparator |
| win_end_i | input | 1 | One-cycle strobe at each measurement window end |
| sleep_i | input | 1 | Low-light sleep state |
| shutdown_i | input | 1 | Shutdown state |
| force_wake_i | input | 1 | Host override forcing wake high |
| src_stat_i | input | 4 | Status bits 4..1 from other blocks |
| irq_rd_i | input | 1 | Interrupt register read strobe |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 5 | Mask write data |
| clamp_mode_i | input | 1 | 1 selects push-pull clamp drive on the interrupt pin |
| voc_meas_i | input | 1 | Open-circuit measurement in progress |
| clamp_req_i | input | 1 | Excess-input clamp request |
| wake_o | output | 1 | Wake output |
| status_o | output | 5 | Status register |
| irq_o | output | 5 | Interrupt register |
| mask_o | output | 5 | Mask register |
| irq_pad_out_o | output | 1 | Interrupt pin output value |
| irq_pad_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The debounce is driven with several comparator histories:
- an unbroken run stopped one strobe short of the limit;
- the same run completed and then saturated;
- runs broken by a drop after partial progress.

Together these separate a correct threshold from one that is off by one, and a counter that restarts from one that merely pauses. Interrupt bits are set by rising and by falling status changes. They are read alone, read in the same cycle as a change, and viewed under masks, which shows whether clearing and setting are ordered correctly. The clamp drive is walked through each of its priority cases, with a reset taken under nonzero status to show that no interrupt is raised at start-up.

// File: rtl/wake_irq_pkg.sv
package wake_irq_pkg;
   localparam int NUM_IRQ  = 5;
   localparam int IDX_WAKE = 0;
   localparam int IDX_EN   = 1;
   localparam int IDX_VVAL = 2;
   localparam int IDX_VRDY = 3;
   localparam int IDX_HRDY = 4;
endpackage

// File: rtl/wake_debounce.sv
module wake_debounce #(
   parameter int DEB_WINDOWS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sys_above_i,
   input  logic win_end_i,
   input  logic hold_i,
   output logic deb_o
);
   localparam int CW = $clog2(DEB_WINDOWS + 1);
   localparam logic [CW-1:0] LIMIT = CW'(DEB_WINDOWS);

   if (DEB_WINDOWS < 2) begin : g_bad_windows
      $error("wake_debounce: DEB_WINDOWS must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (hold_i || !sys_above_i)
         cnt_q <= '0;
      else if (win_end_i && (cnt_q != LIMIT))
         cnt_q <= cnt_q + 1'b1;
   end

   assign deb_o = (cnt_q == LIMIT);

   // R2: a low comparator leaves no debounced level on the next cycle
   a_r2_drop_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_above_i |=> !deb_o);
   // R3: sleep or shutdown clears the debounce state
   a_r3_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> !deb_o);
   // R1: the debounced level only rises on a window strobe with comparator high
   a_r1_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(deb_o) |-> $past(win_end_i && sys_above_i));
endmodule

// File: rtl/irq_change_latch.sv
module irq_change_latch #(
   parameter int NUM = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] stat_i,
   input  logic           rd_i,
   output logic [NUM-1:0] irq_o
);
   if (NUM < 1) begin : g_bad_num
      $error("irq_change_latch: NUM must be positive");
   end

   logic           armed_q;
   logic [NUM-1:0] ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         ref_q   <= '0;
      end else begin
         armed_q <= 1'b1;
         ref_q   <= stat_i;
      end
   end

   for (genvar i = 0; i < NUM; i++) begin : g_bit
      logic flag_q;
      logic edge_seen;
      assign edge_seen = armed_q && (stat_i[i] != ref_q[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_q <= 1'b0;
         else
            flag_q <= (flag_q && !rd_i) || edge_seen;
      end
      assign irq_o[i] = flag_q;

      // R6: a flag only rises after its status bit moved
      a_r6_rise_on_change: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_o[i]) |-> (armed_q && $past(stat_i[i]) != $past(stat_i[i], 2)));
   end

   // R10: nothing is flagged on the first edge after reset
   a_r10_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |=> (irq_o == '0));
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive #(
   parameter bit HAS_CLAMP = 1'b1
) (
   input  logic irq_any_i,
   input  logic clamp_mode_i,
   input  logic shutdown_i,
   input  logic sleep_i,
   input  logic voc_meas_i,
   input  logic clamp_req_i,
   output logic pad_out_o,
   output logic pad_oe_o
);
   if (HAS_CLAMP) begin : g_clamp
      always_comb begin
         if (clamp_mode_i) begin
            pad_oe_o = 1'b1;
            if (shutdown_i)
               pad_out_o = 1'b1;
            else if (voc_meas_i || sleep_i)
               pad_out_o = 1'b0;
            else
               pad_out_o = clamp_req_i;
         end else begin
            pad_oe_o  = irq_any_i;
            pad_out_o = 1'b0;
         end
      end
   end else begin : g_od_only
      logic unused_in;
      assign unused_in = ^{clamp_mode_i, shutdown_i, sleep_i, voc_meas_i, clamp_req_i};
      assign pad_oe_o  = irq_any_i;
      assign pad_out_o = 1'b0;
   end
endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
   import wake_irq_pkg::*;
#(
   parameter int DEB_WINDOWS = 8,
   parameter bit HAS_CLAMP   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sys_above_i,
   input  logic               win_end_i,
   input  logic               sleep_i,
   input  logic               shutdown_i,
   input  logic               force_wake_i,
   input  logic [NUM_IRQ-2:0] src_stat_i,
   input  logic               irq_rd_i,
   input  logic               mask_wr_i,
   input  logic [NUM_IRQ-1:0] mask_wdata_i,
   input  logic               clamp_mode_i,
   input  logic               voc_meas_i,
   input  logic               clamp_req_i,
   output logic               wake_o,
   output logic [NUM_IRQ-1:0] status_o,
   output logic [NUM_IRQ-1:0] irq_o,
   output logic [NUM_IRQ-1:0] mask_o,
   output logic               irq_pad_out_o,
   output logic               irq_pad_oe_o
);
   logic hold;
   logic deb;
   logic cmp_wake;
   logic [NUM_IRQ-1:0] mask_q;

   assign hold = sleep_i || shutdown_i;

   wake_debounce #(.DEB_WINDOWS(DEB_WINDOWS)) u_deb (
      .clk(clk), .rst_n(rst_n), .sys_above_i(sys_above_i),
      .win_end_i(win_end_i), .hold_i(hold), .deb_o(deb)
   );

   assign cmp_wake = deb && !hold;
   assign wake_o   = !hold && (deb || force_wake_i);
   assign status_o = {src_stat_i, !cmp_wake};

   irq_change_latch #(.NUM(NUM_IRQ)) u_irq (
      .clk(clk), .rst_n(rst_n), .stat_i(status_o), .rd_i(irq_rd_i), .irq_o(irq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (mask_wr_i)
         mask_q <= mask_wdata_i;
   end
   assign mask_o = mask_q;

   irq_pin_drive #(.HAS_CLAMP(HAS_CLAMP)) u_pin (
      .irq_any_i(|(irq_o & ~mask_q)), .clamp_mode_i(clamp_mode_i),
      .shutdown_i(shutdown_i), .sleep_i(sleep_i), .voc_meas_i(voc_meas_i),
      .clamp_req_i(clamp_req_i), .pad_out_o(irq_pad_out_o), .pad_oe_o(irq_pad_oe_o)
   );

   // R8: with every pending source masked the open-drain pin stays released
   a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!clamp_mode_i && ((irq_o & ~mask_o) == '0)) |-> !irq_pad_oe_o);
   // R5: wake status never reports high wake while the chip is held
   a_r5_status_held: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> status_o[IDX_WAKE]);
endmodule

// File: tb/wake_irq_ctrl_test.sv
module wake_irq_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sys_above = 1'b0, win_end = 1'b0, sleep = 1'b0, shutdown = 1'b0;
   logic       force_wake = 1'b0;
   logic [3:0] src = 4'b0;
   logic       irq_rd = 1'b0, mask_wr = 1'b0;
   logic [4:0] mask_wdata = 5'b0;
   logic       clamp_mode = 1'b0, voc_meas = 1'b0, clamp_req = 1'b0;
   logic       wake;
   logic [4:0] status, irq, mask;
   logic       pad_out, pad_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wake_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .sys_above_i(sys_above), .win_end_i(win_end),
      .sleep_i(sleep), .shutdown_i(shutdown), .force_wake_i(force_wake),
      .src_stat_i(src), .irq_rd_i(irq_rd), .mask_wr_i(mask_wr),
      .mask_wdata_i(mask_wdata), .clamp_mode_i(clamp_mode), .voc_meas_i(voc_meas),
      .clamp_req_i(clamp_req), .wake_o(wake), .status_o(status), .irq_o(irq),
      .mask_o(mask), .irq_pad_out_o(pad_out), .irq_pad_oe_o(pad_oe)
   );

   // {sys_above, strobes[3:0], expected wake}
   localparam logic [5:0] VEC [8] = '{
      {1'b1, 4'd7, 1'b0}, {1'b1, 4'd1, 1'b1}, {1'b1, 4'd3, 1'b1},
      {1'b0, 4'd0, 1'b0}, {1'b1, 4'd5, 1'b0}, {1'b0, 4'd1, 1'b0},
      {1'b1, 4'd7, 1'b0}, {1'b1, 4'd1, 1'b1}};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic strobe(input int n);
      for (int k = 0; k < n; k++) begin
         win_end = 1'b1;
         tick();
         win_end = 1'b0;
         tick();
      end
   endtask

   task automatic rd_clear();
      irq_rd = 1'b1;
      tick();
      irq_rd = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      @(negedge clk);
      tick();
      rst_n = 1'b1;
      // reset state
      check("R5 reset status", status, 5'b00001);
      check("R8 reset irq", irq, 5'b0);
      check("R8 reset pad_oe", pad_oe, 1'b0);
      check("R1 reset wake", wake, 1'b0);
      tick();

      // R1 R2: debounce vector walk
      foreach (VEC[i]) begin
         sys_above = VEC[i][5];
         tick();
         strobe(int'(VEC[i][4:1]));
         check($sformatf("R1/R2 vector %0d", i), wake, VEC[i][0]);
      end

      // R5: status polarity with wake debounced high
      check("R5 status wake high", status[0], 1'b0);

      // R3: sleep and shutdown force low and clear the count
      sleep = 1'b1; force_wake = 1'b1;
      tick();
      check("R3 sleep low with override", wake, 1'b0);
      sleep = 1'b0; force_wake = 1'b0;
      tick();
      check("R3 count cleared after sleep", wake, 1'b0);
      strobe(8);
      check("R1 re-debounced", wake, 1'b1);
      shutdown = 1'b1;
      tick();
      check("R3 shutdown low", wake, 1'b0);
      shutdown = 1'b0;
      tick();

      // R4 R5: override with comparator low
      sys_above = 1'b0; force_wake = 1'b1;
      tick();
      check("R4 override high", wake, 1'b1);
      check("R5 status ignores override", status[0], 1'b1);
      force_wake = 1'b0;
      tick();

      // R6: rising and falling changes
      rd_clear();
      check("R7 read clears all", irq, 5'b0);
      src[3] = 1'b1;
      tick();
      check("R6 rise sets harvest bit", irq, 5'b10000);
      rd_clear();
      src[3] = 1'b0;
      tick();
      check("R6 fall sets harvest bit", irq, 5'b10000);
      check("R8 open-drain pulls low", {pad_oe, pad_out}, 2'b10);

      // R8: masking
      mask_wdata = 5'b10000; mask_wr = 1'b1;
      tick();
      mask_wr = 1'b0;
      check("R8 mask loaded", mask, 5'b10000);
      check("R8 masked pin released", pad_oe, 1'b0);
      mask_wdata = 5'b0; mask_wr = 1'b1;
      tick();
      mask_wr = 1'b0;
      check("R8 unmasked pin asserted", pad_oe, 1'b1);

      // R7: read and change in the same cycle
      src[2] = 1'b1;
      tick();
      check("R6 voc-ready bit set", irq, 5'b11000);
      src[0] = 1'b1; irq_rd = 1'b1;
      tick();
      irq_rd = 1'b0;
      check("R7 new bit survives read", irq, 5'b00010);
      rd_clear();

      // R9: clamp mode priorities
      clamp_mode = 1'b1; clamp_req = 1'b1; shutdown = 1'b1; voc_meas = 1'b1;
      #1;
      check("R9 shutdown drives high", {pad_oe, pad_out}, 2'b11);
      shutdown = 1'b0;
      #1;
      check("R9 voc measurement disables", {pad_oe, pad_out}, 2'b10);
      voc_meas = 1'b0; sleep = 1'b1;
      #1;
      check("R9 sleep disables", {pad_oe, pad_out}, 2'b10);
      sleep = 1'b0;
      #1;
      check("R9 follows request high", {pad_oe, pad_out}, 2'b11);
      clamp_req = 1'b0;
      #1;
      check("R9 follows request low", {pad_oe, pad_out}, 2'b10);
      clamp_mode = 1'b0;
      tick();

      // R10: reset under nonzero status
      rst_n = 1'b0;
      src = 4'b1010;
      tick();
      rst_n = 1'b1;
      tick();
      tick();
      check("R10 no start-up interrupt", irq, 5'b0);
      check("R6 status positions", status, 5'b10101);

      finish_run();
   end
endmodule